// File: doc/BRIEF.md
# Montgomery Reduction Coefficient Generator

This block computes the coefficient that Montgomery reduction needs, the value R = -N^-1 mod 2^W, for an odd modulus N. The coefficient is W = MOD_W + EXTRA_W bits wide. The default adds one 16-bit word beyond the modulus width, which supports a reduction variant that processes one extra word. The modulus is zero-extended to W bits before use.

The block fixes one bit of the coefficient per iteration. It starts from R = 1 with a one-hot bit weight of 1. In each of the W-1 iterations it shifts the weight left and forms the trial product T = R * (-N) mod 2^W. If the bit of T at the weight's position is set, it adds the weight to R. The trial product comes from a serial shift-and-add multiplier that always runs exactly W steps. The control never branches on data, so the run time is the same for every modulus. This matters because the block also serves the secret primes of a CRT key.

A one-cycle `start` pulse samples the modulus. `busy` covers the computation. A one-cycle `done` pulse marks the point where `coef` holds the result.

Top module: `mont_coef_gen`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `coef` is 0.
- R2: `start` is accepted on an edge where `busy` is 0, and `busy` is 1 in the cycle that follows.
- R3: When `done` is 1 for an odd sampled modulus N, the value (coef * N + 1) mod 2^W is 0, where W = MOD_W + EXTRA_W and N is zero-extended to W bits.
- R4: `done` rises exactly (W-1)*(W+2) clock edges after the accepting edge, for every modulus value, even or odd. `busy` stays 1 in every cycle from the accepting edge up to `done`.
- R5: `done` is a single-cycle pulse, and `busy` is 0 while `done` is 1.
- R6: `start` is ignored while `busy` is 1. A change of `modIn` after the accepting edge has no effect on the result.
- R7: While `busy` is 0 and `start` is 0, `coef` and `err` keep their values.
- R8: `err` takes the value 1 at the accepting edge when bit 0 of the sampled modulus is 0, and 0 otherwise. It keeps that value until the next accepted start.
- R9: A `start` in the same cycle as `done` is accepted. The next computation then runs with the full latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin; samples `modIn` when accepted |
| modIn | input | MOD_W | Modulus N, expected odd |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `coef` holds the result |
| err | output | 1 | Sampled modulus was even |
| coef | output | MOD_W+EXTRA_W | Coefficient -N^-1 mod 2^W |

## Verification
The completion pulse and a new request can fall in the same cycle. The bench provokes this by raising `start` at the falling edge where it first sees `done`. This tests that the new run is accepted while the finished coefficient is still presented for that one cycle. The behavioural reference model in the bench follows both events on every edge. It judges the overlap on two points. The new run must end after the full fixed latency (R4), and its result must match an inverse that the bench computes independently by Newton iteration (R9). A second overlap is a `start` together with a changed modulus while `busy` is high. The model expects no effect from it (R6).

// File: rtl/mont_coef_pkg.sv
package mont_coef_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_MUL,
    ST_FIX,
    ST_DONE
  } coef_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture modulus, seed coefficient and weight
    logic prep;   // advance weight, arm multiplier
    logic step;   // one shift-and-add step
    logic fix;    // conditional add of the weight
  } coef_stb_t;

endpackage

// File: rtl/mont_coef_ctrl.sv
module mont_coef_ctrl
  import mont_coef_pkg::*;
#(
  parameter int COEF_W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output coef_stb_t stb,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = (COEF_W > 2) ? $clog2(COEF_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COEF_W - 1);

  coef_state_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] iterCnt;
  logic accept;

  always_comb begin
    accept    = start && (state == ST_IDLE || state == ST_DONE);
    stb       = '0;
    stb.load  = accept;
    stb.prep  = (state == ST_PREP);
    stb.step  = (state == ST_MUL);
    stb.fix   = (state == ST_FIX);
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = ST_PREP;
      ST_PREP: stateNext = ST_MUL;
      ST_MUL:  if (stepCnt == LAST) stateNext = ST_FIX;
      ST_FIX:  stateNext = (iterCnt == LAST) ? ST_DONE : ST_PREP;
      ST_DONE: stateNext = accept ? ST_PREP : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      iterCnt <= '0;
    end else begin
      state <= stateNext;
      if (accept) iterCnt <= CNT_W'(1);
      else if (state == ST_FIX && iterCnt != LAST) iterCnt <= iterCnt + 1'b1;
      if (state == ST_MUL) stepCnt <= (stepCnt == LAST) ? '0 : stepCnt + 1'b1;
      else stepCnt <= '0;
    end
  end

  assign busy = (state == ST_PREP) || (state == ST_MUL) || (state == ST_FIX);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/mont_coef_datapath.sv
module mont_coef_datapath
  import mont_coef_pkg::*;
#(
  parameter int MOD_W  = 16,
  parameter int COEF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  coef_stb_t         stb,
  input  logic [MOD_W-1:0]  modIn,
  output logic [COEF_W-1:0] coef,
  output logic              err
);

  logic [COEF_W-1:0] rReg;     // coefficient under construction
  logic [COEF_W-1:0] bReg;     // one-hot bit weight
  logic [COEF_W-1:0] nnReg;    // negated modulus
  logic [COEF_W-1:0] accReg;   // trial product accumulator
  logic [COEF_W-1:0] mplReg;   // multiplier operand, shifts right
  logic [COEF_W-1:0] addReg;   // multiplicand, shifts left
  logic              errReg;

  logic [COEF_W-1:0] modExt;
  logic [COEF_W-1:0] partial;
  logic              trialBit;

  always_comb begin
    modExt   = COEF_W'(modIn);
    partial  = mplReg[0] ? addReg : '0;
    trialBit = |(accReg & bReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rReg   <= '0;
      bReg   <= '0;
      nnReg  <= '0;
      accReg <= '0;
      mplReg <= '0;
      addReg <= '0;
      errReg <= 1'b0;
    end else begin
      if (stb.load) begin
        rReg   <= COEF_W'(1);
        bReg   <= COEF_W'(1);
        nnReg  <= ~modExt + 1'b1;
        errReg <= ~modIn[0];
      end
      if (stb.prep) begin
        bReg   <= bReg << 1;
        accReg <= '0;
        mplReg <= rReg;
        addReg <= nnReg;
      end
      if (stb.step) begin
        accReg <= accReg + partial;
        mplReg <= mplReg >> 1;
        addReg <= addReg << 1;
      end
      if (stb.fix && trialBit) rReg <= rReg + bReg;
    end
  end

  assign coef = rReg;
  assign err  = errReg;

endmodule

// File: rtl/mont_coef_gen.sv
module mont_coef_gen
  import mont_coef_pkg::*;
#(
  parameter int MOD_W   = 16,
  parameter int EXTRA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [MOD_W-1:0]         modIn,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [MOD_W+EXTRA_W-1:0] coef
);

  localparam int COEF_W = MOD_W + EXTRA_W;

  coef_stb_t stb;

  mont_coef_ctrl #(.COEF_W(COEF_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .busy (busy),
    .done (done)
  );

  mont_coef_datapath #(.MOD_W(MOD_W), .COEF_W(COEF_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .modIn(modIn),
    .coef (coef),
    .err  (err)
  );

endmodule

// File: rtl/mont_coef_chk.sv
module mont_coef_chk #(
  parameter int MOD_W   = 16,
  parameter int EXTRA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic [MOD_W-1:0]         modIn,
  input logic                     busy,
  input logic                     done,
  input logic                     err,
  input logic [MOD_W+EXTRA_W-1:0] coef
);

  localparam int W = MOD_W + EXTRA_W;
  localparam int unsigned LAT = (W - 1) * (W + 2);
  localparam logic [W-1:0] ONE = W'(1);

  logic             run;
  int unsigned      cnt;
  logic [MOD_W-1:0] modLat;
  logic [W-1:0]     chkProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run    <= 1'b0;
      cnt    <= 0;
      modLat <= '0;
    end else if (start && !busy) begin
      run    <= 1'b1;
      cnt    <= 0;
      modLat <= modIn;
    end else if (run) begin
      cnt <= cnt + 1;
      if (done) run <= 1'b0;
    end
  end

  always_comb chkProd = coef * W'(modLat);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err) |-> ((chkProd + ONE) == '0));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (done == (cnt == LAT)));

  // R4
  busy_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !done) |-> busy);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(coef) && $stable(err)));

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (err == !modLat[0]));

endmodule

bind mont_coef_gen mont_coef_chk #(.MOD_W(MOD_W), .EXTRA_W(EXTRA_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .modIn(modIn),
  .busy (busy),
  .done (done),
  .err  (err),
  .coef (coef)
);

// File: tb/mont_coef_gen_bench.sv
module mont_coef_gen_bench;

  localparam int MOD_W   = 16;
  localparam int EXTRA_W = 16;
  localparam int W       = MOD_W + EXTRA_W;
  localparam int LAT     = (W - 1) * (W + 2);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [MOD_W-1:0] modIn = '0;
  logic             busy, done, err;
  logic [W-1:0]     coef;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mont_coef_gen #(.MOD_W(MOD_W), .EXTRA_W(EXTRA_W)) u_mont_coef_gen (
    .clk(clk), .rstN(rstN), .start(start), .modIn(modIn),
    .busy(busy), .done(done), .err(err), .coef(coef)
  );

  // independent reference: Newton iteration for the inverse, then negate
  function automatic logic [W-1:0] refCoef(input logic [MOD_W-1:0] n);
    longint unsigned nn, x;
    logic [63:0] neg;
    nn = 64'(n);
    x  = nn;
    for (int k = 0; k < 6; k++) x = x * (64'd2 - nn * x);
    neg = -x;
    return neg[W-1:0];
  endfunction

  task automatic check(input string tag, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on each rising edge
  logic         mBusy = 1'b0, mDone = 1'b0, mErr = 1'b0, mCoefValid = 1'b1;
  logic [W-1:0] mCoef = '0, mPending = '0;
  logic         mPendValid = 1'b0;
  int           mRemain = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mErr = 0; mCoef = '0; mCoefValid = 1; mRemain = 0;
    end else if (start && !mBusy) begin
      mBusy = 1; mDone = 0; mRemain = LAT; mErr = !modIn[0];
      mCoefValid = 0; mPending = refCoef(modIn); mPendValid = modIn[0];
    end else if (mBusy) begin
      mRemain--;
      if (mRemain == 0) begin
        mBusy = 0; mDone = 1; mCoef = mPending; mCoefValid = mPendValid;
      end
    end else begin
      mDone = 0;
    end
  end

  logic [W-1:0] nExt, prodChk;
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 busy", busy == mBusy, 64'(busy), 64'(mBusy));
      check("R4 done timing", done == mDone, 64'(done), 64'(mDone));
      check("R8 err", err == mErr, 64'(err), 64'(mErr));
      if (mCoefValid) check("R3 coef", coef == mCoef, 64'(coef), 64'(mCoef));
      if (done && mDone) check("R5 busy low at done", !busy, 64'(busy), 64'(0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // start a run and wait for done; checks latency
  task automatic runOne(input logic [MOD_W-1:0] n, input string tag);
    int n2 = 0;
    start = 1'b1;
    modIn = n;
    do begin
      @(negedge clk);
      n2++;
      if (n2 == 1) start = 1'b0;
    end while (!done && n2 < LAT + 10);
    check("R4 latency", n2 == LAT + 1, 64'(n2), 64'(LAT + 1));
    if (n[0]) begin
      nExt = W'(n);
      prodChk = coef * nExt + W'(1);
      check(tag, prodChk == '0, 64'(prodChk), 64'(0));
    end
  endtask

  initial begin
    logic [W-1:0] held;
    logic [MOD_W-1:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy == 0, 64'(busy), 0);
    check("R1 done", done == 0, 64'(done), 0);
    check("R1 err", err == 0, 64'(err), 0);
    check("R1 coef", coef == '0, 64'(coef), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOne(16'h0001, "R3 N=1");
    check("R3 N=1 all ones", coef == '1, 64'(coef), 64'({W{1'b1}}));
    @(negedge clk);
    runOne(16'hFFFF, "R3 N=max");
    @(negedge clk);
    runOne(16'h0003, "R3 N=3");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      r = MOD_W'($urandom) | 16'h0001;
      runOne(r, "R3 random");
    end

    // R7: hold while idle
    held = coef;
    repeat (20) @(negedge clk);
    check("R7 hold coef", coef == held, 64'(coef), 64'(held));

    // R6: start and modulus changes while busy are ignored
    start = 1'b1; modIn = 16'h1235;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; modIn = 16'h0BAD;
    @(negedge clk);
    start = 1'b0; modIn = 16'h7777;
    while (!done) @(negedge clk);
    check("R6 ignore busy start", coef == refCoef(16'h1235),
          64'(coef), 64'(refCoef(16'h1235)));

    // R9: start in the done cycle
    runOne(16'hA5A5 | 16'h1, "R9 back-to-back result");
    check("R9 back-to-back coef", coef == refCoef(16'hA5A5),
          64'(coef), 64'(refCoef(16'hA5A5)));

    // R8: even modulus raises err, same latency
    @(negedge clk);
    runOne(16'h0010, "R8 even");
    check("R8 err even", err == 1'b1, 64'(err), 1);
    @(negedge clk);
    runOne(16'h0011, "R8 odd clears");
    check("R8 err odd", err == 1'b0, 64'(err), 0);

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule